// File: doc/BRIEF.md
# Three-Channel Converter Code Register Front End

This block is the digital side of a three-channel 8-bit voltage converter. A single 8-bit data port, a 2-bit address and an active-low write strobe load code registers, one for each channel. The registers drive the converter taps, and the block also presents each channel's ideal output level in millivolts. That level is the code scaled by the supply voltage over 256, so it tracks the supply.

The address value one past the last channel is a command and not a register. A write there puts the converter into a low-power state, and the data lines are ignored for that write. While the block is in that state every channel output is marked as high impedance. The next write to any channel address leaves the low-power state and stores its data as usual. No stored code is lost across the low-power period. Power-on reset clears every code to zero and starts the block in the active state.

The strobe is sampled on the clock. For each clock edge on which the strobe is low, the addressed register takes the data present at that edge. The register therefore follows the data bus for as long as the strobe stays low, and it holds its value once the strobe returns high.

Top module: `trichan_dac_front`

## Requirements
- R1: After reset, all three codes read 0x00, `shdn_o` is 0 and `out_en_o` is 3'b111.
- R2: On a clock edge with `wr_n`=0, address 0 loads `data` into channel A (`codes_o[7:0]`), address 1 into channel B (`codes_o[15:8]`) and address 2 into channel C (`codes_o[23:16]`). The other channels are not changed.
- R3: While `wr_n` stays low, the addressed code takes the new `data` on every edge. While `wr_n` is high, no code changes, whatever is on `data` or `addr`.
- R4: On an edge with `wr_n`=0 and address 3, `shdn_o` becomes 1. All three codes keep their values and `data` is ignored.
- R5: `out_en_o` is 3'b000 while `shdn_o` is 1 and 3'b111 while it is 0 (bit k belongs to channel k).
- R6: On an edge with `wr_n`=0 and address 0, 1 or 2, `shdn_o` becomes 0 and the addressed code is loaded. The codes stored before the low-power period are kept.
- R7: For each channel k, `level_mv_o[k*13 +: 13]` equals floor(code_k × 3300 / 256), with the default 3300 mV supply.
- R8: While `wr_n` is high, `shdn_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Channel select (0..2) or low-power command (3) |
| data | input | 8 | Shared code input |
| codes_o | output | 24 | Held codes, channel A in the low byte |
| level_mv_o | output | 39 | Ideal output level per channel, 13 bits each, in mV |
| shdn_o | output | 1 | Low-power state flag |
| out_en_o | output | 3 | Per-channel output drive enable; 0 means high impedance |

## Verification
The assertions assume that `wr_n`, `addr` and `data` are synchronous to `clk` and settle well before each rising edge. Under that assumption, the values seen at an edge are the values of a write. The bench changes all inputs only on the falling edge and samples outputs on the next falling edge, so every rising edge sees stable values. Writes with a held-low strobe, writes while the strobe is high and repeated low-power commands are all applied in that way.

// File: rtl/trichan_pkg.sv
package trichan_pkg;
  // Ideal converter level: code scaled by supply over 2**code_width.
  function automatic int unsigned code_to_mv(input int unsigned code,
                                             input int unsigned vdd_mv,
                                             input int unsigned cw);
    return (code * vdd_mv) >> cw;
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic [NCH-1:0] chan_wr,
  output logic          shdn_cmd,
  output logic          wake_cmd
);
  localparam logic [AW-1:0] SHDN_ADDR = AW'(NCH);

  logic wr_stb;
  assign wr_stb = ~wr_n;

  for (genvar k = 0; k < NCH; k++) begin : g_sel
    assign chan_wr[k] = wr_stb && (addr == AW'(k));
  end

  assign shdn_cmd = wr_stb && (addr == SHDN_ADDR);
  assign wake_cmd = |chan_wr;

  always_comb begin
    a_r2_one_target: assert ($onehot0({chan_wr, shdn_cmd}));
  end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code <= '0;
    else if (load)  code <= din;
  end

  a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> code == $past(din));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code));
endmodule

// File: rtl/dac_mode_ctrl.sv
module dac_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_cmd,
  input  logic wake_cmd,
  output logic shdn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shdn <= 1'b0;
    else if (shdn_cmd) shdn <= 1'b1;
    else if (wake_cmd) shdn <= 1'b0;
  end

  a_r4_enter_low_power: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_cmd |=> shdn);
  a_r6_leave_low_power: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cmd |=> !shdn);
  a_r8_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_cmd && !wake_cmd) |=> $stable(shdn));
endmodule

// File: rtl/trichan_dac_front.sv
module trichan_dac_front #(
  parameter int NCH    = 3,
  parameter int CW     = 8,
  parameter int VDD_MV = 3300,
  parameter int MVW    = 13,
  parameter int AW     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [CW-1:0]      data,
  output logic [NCH*CW-1:0]  codes_o,
  output logic [NCH*MVW-1:0] level_mv_o,
  output logic               shdn_o,
  output logic [NCH-1:0]     out_en_o
);
  import trichan_pkg::*;

  logic [NCH-1:0] chan_wr;
  logic           shdn_cmd;
  logic           wake_cmd;
  logic           shdn;

  dac_addr_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_n(wr_n), .addr(addr), .chan_wr(chan_wr),
    .shdn_cmd(shdn_cmd), .wake_cmd(wake_cmd)
  );

  dac_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .shdn_cmd(shdn_cmd),
    .wake_cmd(wake_cmd), .shdn(shdn)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [CW-1:0] code_q;
    dac_chan_reg #(.CW(CW)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(chan_wr[k]),
      .din(data), .code(code_q)
    );
    assign codes_o[k*CW +: CW]     = code_q;
    assign level_mv_o[k*MVW +: MVW] =
      MVW'(code_to_mv(int'(code_q), VDD_MV, CW));
  end

  assign shdn_o   = shdn;
  assign out_en_o = {NCH{~shdn}};

  // R4: the command write leaves every stored code alone
  a_r4_codes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr == AW'(NCH)) |=> $stable(codes_o));
  // R8: an idle strobe changes neither codes nor mode
  a_r8_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(codes_o) && $stable(shdn_o)));
  // R5: drive enables and mode flag move together
  a_r5_enable_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_o) |-> out_en_o == '0);
endmodule

// File: tb/trichan_dac_front_tb_top.sv
module trichan_dac_front_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [23:0] codes_o;
  logic [38:0] level_mv_o;
  logic        shdn_o;
  logic [2:0]  out_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  trichan_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
    .codes_o(codes_o), .level_mv_o(level_mv_o), .shdn_o(shdn_o),
    .out_en_o(out_en_o)
  );

  // {wr_n, addr, data, expect A, expect B, expect C, expect shdn}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h5A, 8'h5A, 8'h00, 8'h00, 1'b0},
    {1'b0, 2'd1, 8'hC3, 8'h5A, 8'hC3, 8'h00, 1'b0},
    {1'b0, 2'd2, 8'hFF, 8'h5A, 8'hC3, 8'hFF, 1'b0},
    {1'b1, 2'd0, 8'h11, 8'h5A, 8'hC3, 8'hFF, 1'b0},
    {1'b0, 2'd0, 8'h12, 8'h12, 8'hC3, 8'hFF, 1'b0},
    {1'b0, 2'd0, 8'h34, 8'h34, 8'hC3, 8'hFF, 1'b0},
    {1'b0, 2'd3, 8'hAA, 8'h34, 8'hC3, 8'hFF, 1'b1},
    {1'b1, 2'd1, 8'h00, 8'h34, 8'hC3, 8'hFF, 1'b1},
    {1'b0, 2'd3, 8'h55, 8'h34, 8'hC3, 8'hFF, 1'b1},
    {1'b0, 2'd1, 8'h01, 8'h34, 8'h01, 8'hFF, 1'b0},
    {1'b0, 2'd3, 8'h00, 8'h34, 8'h01, 8'hFF, 1'b1},
    {1'b0, 2'd2, 8'h80, 8'h34, 8'h01, 8'h80, 1'b0},
    {1'b0, 2'd0, 8'h00, 8'h00, 8'h01, 8'h80, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Level computed as ideal ratio, rounded down
  function automatic int mv_of(input int code);
    return int'((longint'(code) * 3300) / 256);
  endfunction

  task automatic check_all(input string tag, input int ea, input int eb,
                           input int ec, input int es);
    chk({tag, " R2 code A"}, int'(codes_o[7:0]), ea);
    chk({tag, " R2 code B"}, int'(codes_o[15:8]), eb);
    chk({tag, " R2 code C"}, int'(codes_o[23:16]), ec);
    chk({tag, " R4/R6 shdn"}, int'(shdn_o), es);
    chk({tag, " R5 out_en"}, int'(out_en_o), es ? 0 : 7);
    chk({tag, " R7 level A"}, int'(level_mv_o[12:0]), mv_of(ea));
    chk({tag, " R7 level B"}, int'(level_mv_o[25:13]), mv_of(eb));
    chk({tag, " R7 level C"}, int'(level_mv_o[38:26]), mv_of(ec));
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_n = w; addr = a; data = d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0, 0, 0, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35], VEC[i][34:33], VEC[i][32:25]);
      check_all($sformatf("R3 vec%0d", i), int'(VEC[i][24:17]),
                int'(VEC[i][16:9]), int'(VEC[i][8:1]), int'(VEC[i][0]));
    end

    // R7 boundaries: full scale and mid scale
    step(1'b0, 2'd0, 8'hFF);
    chk("R7 full scale", int'(level_mv_o[12:0]), 3287);
    step(1'b0, 2'd1, 8'h80);
    chk("R7 mid scale", int'(level_mv_o[25:13]), 1650);

    // R3: idle strobe with changing bus, held over several edges
    step(1'b1, 2'd0, 8'h00);
    step(1'b1, 2'd2, 8'h3C);
    check_all("R3 idle", 8'hFF, 8'h80, 8'h80, 0);

    // R4 then R1: reset out of low-power state
    step(1'b0, 2'd3, 8'h99);
    check_all("R4 enter", 8'hFF, 8'h80, 8'h80, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 reset from low power", 0, 0, 0, 0);
    rst_n = 1'b1;
    wr_n = 1'b1;

    // R6: wake through channel C keeps A and B at reset value
    step(1'b0, 2'd3, 8'h01);
    step(1'b0, 2'd2, 8'h07);
    check_all("R6 wake C", 0, 0, 8'h07, 0);
    step(1'b1, 2'd2, 8'h07);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule